// File: doc/BRIEF.md
# Configuration Capability Chain Seeker

This block searches the 256-byte configuration space of a device for a capability structure with a requested identifier. The capability structures form a singly linked list inside that space. The block has one byte-wide read/write port into the configuration memory and follows the list one byte read at a time. For each search it reports whether the identifier was found, the offset of the matching structure, and the location of the pointer byte that refers to that structure.

A search can also remove the matching structure from the chain. To do this the block copies the structure's forward pointer into the pointer byte that referenced it. If the chain is empty after the removal, the block clears the capability-present flag in the status byte. A counter limits the number of hops, so a corrupted or circular chain cannot hold the engine forever. Allocating room for new structures is left to other logic.

Top module: `cap_chain_seeker`

## Requirements
- R1: After a synchronous active-low reset, `done_o`, `found_o`, `rd_en_o` and `wr_en_o` are 0, and `cap_off_o` and `prev_off_o` are 0x00.
- R2: Each search first reads the status byte at offset 0x06. If bit 4 of that byte is 0, the search ends as not found. `done_o` pulses 2 cycles after the clock edge that accepts `start_i`, and no other read or write takes place.
- R3: The walk reads the head pointer byte at offset 0x34. A pointer value of 0x00 ends the walk as not found. With a zero head, `done_o` comes 4 cycles after acceptance. When a search fails after examining n structures, `done_o` comes 4+4n cycles after acceptance.
- R4: A structure at offset P holds its identifier byte at P and its forward pointer byte at P+1. On a match, `found_o`=1, `cap_off_o`=P, and `prev_off_o` is the location of the referencing pointer. That location is 0x34 for the first structure and Q+1 when the referencing structure sits at Q.
- R5: Each memory read has one cycle of latency, and each structure visited costs 4 cycles. A plain search that matches the n-th structure raises `done_o` 2+4n cycles after acceptance.
- R6: After `MAX_HOPS` (default 48) structures have been examined without a match, the search ends as not found when the next non-zero pointer is met. For a circular chain this takes 4+4*48 = 196 cycles.
- R7: When `unlink_i` is 1 at acceptance and the identifier is found, the forward pointer byte of the matching structure is written into `prev_off_o`'s location. If the identifier is not found, no write occurs.
- R8: After an unlink, the head byte at 0x34 is re-read. If it is 0x00, bit 4 of the status byte is cleared and its other bits are kept; `done_o` then comes 8+4n cycles after acceptance. Otherwise the status byte is untouched and `done_o` comes 6+4n cycles after acceptance.
- R9: `done_o` is a single-cycle pulse. `found_o`, `cap_off_o` and `prev_off_o` change only when `done_o` rises or at an accepted start, which clears them to 0. A `start_i` pulse while a search is running is ignored.
- R10: The memory port performs at most one access per cycle: never a read and a write together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a search (accepted only when idle) |
| cap_id_i | input | 8 | Identifier to look for |
| unlink_i | input | 1 | Remove the matching structure from the chain |
| rd_en_o | output | 1 | Memory read strobe |
| wr_en_o | output | 1 | Memory write strobe |
| addr_o | output | 8 | Memory byte address |
| wr_data_o | output | 8 | Memory write data |
| rd_data_i | input | 8 | Memory read data, valid the cycle after `rd_en_o` |
| done_o | output | 1 | One-cycle completion pulse |
| found_o | output | 1 | Identifier was found |
| cap_off_o | output | 8 | Offset of the matching structure |
| prev_off_o | output | 8 | Location of the pointer that refers to it |

## Verification
Every outcome has a latency fixed by its path, counted from the edge that accepts `start_i`:
- status flag clear: 2 cycles
- zero head: 4 cycles
- plain match at the n-th structure: 2+4n cycles
- failed search after n structures: 4+4n cycles
- unlink: 6+4n cycles, or 8+4n when the status flag must be cleared

The bench counts negative edges from acceptance until `done_o` is seen and compares that count with the formula. It samples the result outputs at that same negative edge. It then checks on the following negative edge that `done_o` has fallen. After each unlink, the bench inspects its own memory model for the rewritten pointer and status byte before it starts the next search.

// File: rtl/cap_walk_pkg.sv
// Shared constants and state encoding for the capability chain seeker.
// Assumes a 256-byte configuration space addressed by byte.
package cap_walk_pkg;
    localparam int          ADDR_W      = 8;
    localparam int          DATA_W      = 8;
    localparam logic [7:0]  STATUS_ADDR = 8'h06;
    localparam logic [7:0]  HEAD_ADDR   = 8'h34;
    localparam int          PRESENT_BIT = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_STAT,  ST_EV_STAT,
        ST_RD_PTR,   ST_EV_PTR,
        ST_RD_ID,    ST_EV_ID,
        ST_RD_NEXT,  ST_WR_PREV,
        ST_RD_HEAD,  ST_EV_HEAD,
        ST_RD_STAT2, ST_WR_STAT2
    } walk_state_t;
endpackage

// File: rtl/cap_hop_guard.sv
// Hop guard: counts the structures visited during one search and flags
// when the configured limit is reached. Assumes clr and inc are never
// asserted together.
module cap_hop_guard #(
    parameter int MAX_HOPS = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int CNT_W = $clog2(MAX_HOPS + 1);

    logic [CNT_W-1:0] hops_q;

    // Count visited structures, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hops_q <= '0;
        end else if (inc && !at_limit) begin
            hops_q <= hops_q + 1'b1;
        end
    end

    assign at_limit = (hops_q == CNT_W'(MAX_HOPS));
endmodule

// File: rtl/cap_walk_ctrl.sv
// Walk controller: sequences the byte reads that follow the capability
// chain, and the writes that unlink a matching structure. Assumes a
// memory whose read data is valid one cycle after the read strobe, and
// that the read data holds its value until the next read.
module cap_walk_ctrl
    import cap_walk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] cap_id_i,
    input  logic              unlink_i,
    output logic              rd_en_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              hop_clr_o,
    output logic              hop_inc_o,
    input  logic              hop_limit_i,
    output logic              done_o,
    output logic              found_o,
    output logic [ADDR_W-1:0] cap_off_o,
    output logic [ADDR_W-1:0] prev_off_o
);
    walk_state_t       state_q;
    logic [DATA_W-1:0] want_q;
    logic              unlink_q;
    logic [ADDR_W-1:0] prev_q;
    logic [ADDR_W-1:0] cur_q;

    logic accept;
    assign accept = (state_q == ST_IDLE) && start_i;

    // Memory port: one access per state, selected by the current state.
    always_comb begin
        rd_en_o   = 1'b0;
        wr_en_o   = 1'b0;
        addr_o    = '0;
        wr_data_o = '0;
        unique case (state_q)
            ST_RD_STAT, ST_RD_STAT2: begin rd_en_o = 1'b1; addr_o = STATUS_ADDR; end
            ST_RD_PTR:   begin rd_en_o = 1'b1; addr_o = prev_q; end
            ST_RD_ID:    begin rd_en_o = 1'b1; addr_o = cur_q; end
            ST_RD_NEXT:  begin rd_en_o = 1'b1; addr_o = cur_q + 1'b1; end
            ST_RD_HEAD:  begin rd_en_o = 1'b1; addr_o = HEAD_ADDR; end
            ST_WR_PREV:  begin wr_en_o = 1'b1; addr_o = prev_q; wr_data_o = rd_data_i; end
            ST_WR_STAT2: begin
                wr_en_o   = 1'b1;
                addr_o    = STATUS_ADDR;
                wr_data_o = rd_data_i & ~(DATA_W'(1) << PRESENT_BIT);
            end
            default: ;
        endcase
    end

    // Hop counter control: clear on acceptance, count each pointer followed.
    assign hop_clr_o = accept;
    assign hop_inc_o = (state_q == ST_EV_PTR) && (rd_data_i != '0) && !hop_limit_i;

    // Sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            want_q     <= '0;
            unlink_q   <= 1'b0;
            prev_q     <= '0;
            cur_q      <= '0;
            done_o     <= 1'b0;
            found_o    <= 1'b0;
            cap_off_o  <= '0;
            prev_off_o <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    want_q     <= cap_id_i;
                    unlink_q   <= unlink_i;
                    found_o    <= 1'b0;
                    cap_off_o  <= '0;
                    prev_off_o <= '0;
                    state_q    <= ST_RD_STAT;
                end
                ST_RD_STAT: state_q <= ST_EV_STAT;
                ST_EV_STAT: begin
                    if (!rd_data_i[PRESENT_BIT]) begin
                        done_o  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        prev_q  <= HEAD_ADDR;
                        state_q <= ST_RD_PTR;
                    end
                end
                ST_RD_PTR: state_q <= ST_EV_PTR;
                ST_EV_PTR: begin
                    if (rd_data_i == '0 || hop_limit_i) begin
                        done_o  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        cur_q   <= rd_data_i;
                        state_q <= ST_RD_ID;
                    end
                end
                ST_RD_ID: state_q <= ST_EV_ID;
                ST_EV_ID: begin
                    if (rd_data_i == want_q) begin
                        if (unlink_q) begin
                            state_q <= ST_RD_NEXT;
                        end else begin
                            found_o    <= 1'b1;
                            cap_off_o  <= cur_q;
                            prev_off_o <= prev_q;
                            done_o     <= 1'b1;
                            state_q    <= ST_IDLE;
                        end
                    end else begin
                        prev_q  <= cur_q + 1'b1;
                        state_q <= ST_RD_PTR;
                    end
                end
                ST_RD_NEXT: state_q <= ST_WR_PREV;
                ST_WR_PREV: state_q <= ST_RD_HEAD;
                ST_RD_HEAD: state_q <= ST_EV_HEAD;
                ST_EV_HEAD: begin
                    if (rd_data_i == '0) begin
                        state_q <= ST_RD_STAT2;
                    end else begin
                        found_o    <= 1'b1;
                        cap_off_o  <= cur_q;
                        prev_off_o <= prev_q;
                        done_o     <= 1'b1;
                        state_q    <= ST_IDLE;
                    end
                end
                ST_RD_STAT2: state_q <= ST_WR_STAT2;
                ST_WR_STAT2: begin
                    found_o    <= 1'b1;
                    cap_off_o  <= cur_q;
                    prev_off_o <= prev_q;
                    done_o     <= 1'b1;
                    state_q    <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cap_chain_seeker.sv
// Top level: capability chain seeker. Joins the walk controller to its
// hop guard. Assumes an external 256-byte configuration memory with a
// one-cycle read latency.
module cap_chain_seeker #(
    parameter int MAX_HOPS = 48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] cap_id_i,
    input  logic       unlink_i,
    output logic       rd_en_o,
    output logic       wr_en_o,
    output logic [7:0] addr_o,
    output logic [7:0] wr_data_o,
    input  logic [7:0] rd_data_i,
    output logic       done_o,
    output logic       found_o,
    output logic [7:0] cap_off_o,
    output logic [7:0] prev_off_o
);
    logic hop_clr;
    logic hop_inc;
    logic hop_limit;

    cap_hop_guard #(.MAX_HOPS(MAX_HOPS)) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (hop_clr),
        .inc      (hop_inc),
        .at_limit (hop_limit)
    );

    cap_walk_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .cap_id_i    (cap_id_i),
        .unlink_i    (unlink_i),
        .rd_en_o     (rd_en_o),
        .wr_en_o     (wr_en_o),
        .addr_o      (addr_o),
        .wr_data_o   (wr_data_o),
        .rd_data_i   (rd_data_i),
        .hop_clr_o   (hop_clr),
        .hop_inc_o   (hop_inc),
        .hop_limit_i (hop_limit),
        .done_o      (done_o),
        .found_o     (found_o),
        .cap_off_o   (cap_off_o),
        .prev_off_o  (prev_off_o)
    );
endmodule

// File: rtl/cap_chain_seeker_chk.sv
// Checker for the capability chain seeker, attached by bind. It observes
// ports only.
module cap_chain_seeker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       rd_en_o,
    input logic       wr_en_o,
    input logic [7:0] addr_o,
    input logic [7:0] wr_data_o,
    input logic       done_o,
    input logic       found_o,
    input logic [7:0] cap_off_o,
    input logic [7:0] prev_off_o
);
    // R1: the first cycle out of reset shows no completion and no access.
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!done_o && !wr_en_o && !found_o));

    // R9: done lasts one cycle.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: results move only on completion or after a start.
    a_r9_results_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({found_o, cap_off_o, prev_off_o}) |-> (done_o || $past(start_i)));

    // R10: never a read and a write together.
    a_r10_single_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en_o && wr_en_o));

    // R8: a write to the status byte always clears the present flag.
    a_r8_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && addr_o == 8'h06) |-> !wr_data_o[4]);
endmodule

bind cap_chain_seeker cap_chain_seeker_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .rd_en_o    (rd_en_o),
    .wr_en_o    (wr_en_o),
    .addr_o     (addr_o),
    .wr_data_o  (wr_data_o),
    .done_o     (done_o),
    .found_o    (found_o),
    .cap_off_o  (cap_off_o),
    .prev_off_o (prev_off_o)
);

// File: tb/cap_chain_seeker_tb_top.sv
// Bench for the capability chain seeker: owns a 256-byte memory model,
// walks a vector table of lookups, then runs directed corner cases.
module cap_chain_seeker_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] cap_id = '0;
    logic       unlink = 1'b0;
    logic       rd_en, wr_en, done, found;
    logic [7:0] addr, wdata, rdata, cap_off, prev_off;

    logic       bt_we = 1'b0;
    logic [7:0] bt_a = '0;
    logic [7:0] bt_d = '0;
    logic [7:0] mem [256];

    int checks = 0;
    int errs   = 0;

    always #2.5 clk = ~clk;

    cap_chain_seeker dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cap_id_i(cap_id),
        .unlink_i(unlink), .rd_en_o(rd_en), .wr_en_o(wr_en), .addr_o(addr),
        .wr_data_o(wdata), .rd_data_i(rdata), .done_o(done), .found_o(found),
        .cap_off_o(cap_off), .prev_off_o(prev_off)
    );

    // Memory model: one-cycle read latency; bench setup writes take priority.
    always @(posedge clk) begin
        if (bt_we) mem[bt_a] <= bt_d;
        else if (wr_en) mem[addr] <= wdata;
        if (rd_en) rdata <= mem[addr];
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bt_we = 1'b1; bt_a = a; bt_d = d;
        @(negedge clk);
        bt_we = 1'b0;
    endtask

    // Chain: 0x34 -> 0x40(id 01) -> 0x50(id 05) -> 0x60(id 10) -> end; status 0x13.
    task automatic build_chain();
        for (int i = 0; i < 256; i++) poke(8'(i), 8'h00);
        poke(8'h06, 8'h13);
        poke(8'h34, 8'h40);
        poke(8'h40, 8'h01); poke(8'h41, 8'h50);
        poke(8'h50, 8'h05); poke(8'h51, 8'h60);
        poke(8'h60, 8'h10); poke(8'h61, 8'h00);
    endtask

    // Run one search; lat is the number of cycles from acceptance to done.
    task automatic run(input logic [7:0] id, input logic unl, output int lat);
        @(negedge clk);
        start = 1'b1; cap_id = id; unlink = unl;
        @(negedge clk);
        start = 1'b0; unlink = 1'b0;
        lat = 0;
        while (!done && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    // Vector fields: {id, found, cap_off, prev_off, latency}.
    localparam logic [39:0] VECS [4] = '{
        {8'h01, 8'h01, 8'h40, 8'h34, 8'd6},
        {8'h05, 8'h01, 8'h50, 8'h41, 8'd10},
        {8'h10, 8'h01, 8'h60, 8'h51, 8'd14},
        {8'h22, 8'h00, 8'h00, 8'h00, 8'd16}
    };

    task automatic main_seq();
        int lat;
        repeat (3) @(negedge clk);
        check("R1", "done", int'(done), 0);
        check("R1", "found", int'(found), 0);
        check("R1", "offsets", int'({cap_off, prev_off}), 0);
        check("R1", "rd/wr", int'({rd_en, wr_en}), 0);
        rst_n = 1'b1;
        build_chain();

        // Table of plain lookups (R3 R4 R5).
        foreach (VECS[v]) begin
            run(VECS[v][39:32], 1'b0, lat);
            check("R4", "found", int'(found), int'(VECS[v][24]));
            check("R4", "cap_off", int'(cap_off), int'(VECS[v][23:16]));
            check("R4", "prev_off", int'(prev_off), int'(VECS[v][15:8]));
            check("R5", "latency", lat, int'(VECS[v][7:0]));
            @(negedge clk);
            check("R9", "done single pulse", int'(done), 0);
            check("R9", "result held", int'(cap_off), int'(VECS[v][23:16]));
        end

        // R2: status flag clear.
        poke(8'h06, 8'h03);
        run(8'h01, 1'b0, lat);
        check("R2", "found", int'(found), 0);
        check("R2", "latency", lat, 2);
        poke(8'h06, 8'h13);

        // R3: zero head pointer.
        poke(8'h34, 8'h00);
        run(8'h01, 1'b0, lat);
        check("R3", "found", int'(found), 0);
        check("R3", "latency", lat, 4);
        poke(8'h34, 8'h40);

        // R6: circular chain stops at the hop limit.
        poke(8'h61, 8'h40);
        run(8'h99, 1'b0, lat);
        check("R6", "found", int'(found), 0);
        check("R6", "latency", lat, 196);
        poke(8'h61, 8'h00);

        // R9: start during a running search is ignored.
        @(negedge clk);
        start = 1'b1; cap_id = 8'h10;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b1; cap_id = 8'h01;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 1000) begin @(negedge clk); lat++; end
        check("R9", "busy start ignored cap_off", int'(cap_off), 8'h60);

        // R7: unlink the middle structure.
        run(8'h05, 1'b1, lat);
        check("R7", "found", int'(found), 1);
        check("R7", "prev_off", int'(prev_off), 8'h41);
        check("R7", "pointer rewritten", int'(mem[8'h41]), 8'h60);
        check("R8", "status kept", int'(mem[8'h06]), 8'h13);
        check("R8", "latency", lat, 14);
        run(8'h05, 1'b0, lat);
        check("R7", "gone", int'(found), 0);
        run(8'h10, 1'b0, lat);
        check("R7", "new prev_off", int'(prev_off), 8'h41);

        // R7: unlink the head structure; chain stays non-empty.
        run(8'h01, 1'b1, lat);
        check("R7", "head rewritten", int'(mem[8'h34]), 8'h60);
        check("R8", "status kept", int'(mem[8'h06]), 8'h13);
        check("R8", "latency", lat, 10);

        // R8: unlink the last structure; present flag cleared.
        run(8'h10, 1'b1, lat);
        check("R8", "head zero", int'(mem[8'h34]), 0);
        check("R8", "status flag cleared", int'(mem[8'h06]), 8'h03);
        check("R8", "latency", lat, 12);

        // R7: failed unlink writes nothing.
        poke(8'h06, 8'h13);
        poke(8'h34, 8'h40);
        run(8'h77, 1'b1, lat);
        check("R7", "not found", int'(found), 0);
        check("R7", "status untouched", int'(mem[8'h06]), 8'h13);
        check("R7", "head untouched", int'(mem[8'h34]), 8'h40);
    endtask

    initial begin
        fork
            main_seq();
            begin
                repeat (100000) @(posedge clk);
                checks++; errs++;
                $display("FAIL watchdog: actual=expired expected=finished");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule